// File: doc/BRIEF.md
# PCM Timeslot Transmit Router

This block sits between a serial PCM transmit stream and three transmit channel FIFOs. A frame holds `NSLOTS` timeslots of eight bits each, one bit per clock. A small table keeps one five-bit entry for every timeslot, and slot 0 may carry framing bits like any other slot. While a timeslot streams in, the block reads that slot's entry. The entry names where the slot's byte comes from and which channels receive it. At the close of the slot the byte is written, in one cycle, to every channel whose mask bit is set.

There are four sources. The first is the serial PCM input. The second is an external insert-data input: it is sampled one slot early through a holding buffer, and the block raises an insert strobe while it samples. The third is a free-running-when-selected test pattern generator. The fourth is a repeat of the byte produced in the previous slot. A slot with an empty mask writes nothing, but its byte still becomes the "previous" byte, so later slots can copy it. A frame-sync pulse aligns the slot counter, and without one the counter wraps on its own.

Top module: `pcm_slot_router`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ch_we` is 000 and all of `ch_data` is zero. Reset also clears the previous-byte register and the insert holding buffer to zero.
- R2: An entry is {source[4:3], mask[2:0]}, and mask bit i selects channel i. In the cycle after the last bit of a slot, `ch_we` equals that slot's mask for exactly one cycle. It is 000 in every other cycle.
- R3: Source 00 (PCM) delivers the eight `pcm_bit` samples of the current slot, with the first sample as bit 7 of the byte.
- R4: A mask of 000 raises no write strobe, but the slot's byte still replaces the previous-byte register.
- R5: Source 11 (previous) delivers the byte produced by the slot just before, whatever that slot's source or mask was.
- R6: `ins_strobe` is high during all eight bit times of slot k exactly when the entry of slot k+1 has source 01. The slot after slot NSLOTS-1 is slot 0.
- R7: Source 01 (insert) delivers the eight `ins_bit` samples taken during the preceding slot, MSB first. After reset, the first insert-sourced slot with no preceding slot delivers zero.
- R8: Source 10 (pattern) delivers the next eight bits of a x^15+x^14+1 sequence, MSB first. The generator is seeded with all ones at reset. Each bit is the XOR of state bits 14 and 13 and is shifted into bit 0. The generator advances only during pattern slots, so the sequence continues across slots that are not adjacent.
- R9: A cycle with `fsync` high is bit 0 of slot 0. Without `fsync`, the slot after NSLOTS-1 is slot 0.
- R10: The `ch_data` byte of a channel keeps its value in every cycle in which that channel is not written.
- R11: An entry written through `cfg_we`/`cfg_addr`/`cfg_data` governs that slot from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one PCM bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Marks bit 0 of slot 0 |
| pcm_bit | input | 1 | Serial PCM data |
| ins_bit | input | 1 | Serial insert data |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | SW | Table entry index (slot number) |
| cfg_data | input | 5 | Entry {source, mask} |
| ins_strobe | output | 1 | Insert data is being sampled |
| ch_we | output | 3 | Per-channel FIFO write strobe |
| ch_data | output | 24 | Channel i byte at bits [8i+7:8i] |

## Verification
Two functions can act in the same slot. First, the insert strobe for slot k+1 is raised while slot k's byte is being assembled and written. Second, a discarded slot still loads the repeat register at the moment a write to another slot would occur. The vector frame puts an insert slot right after a pattern slot, and a repeat slot right after a masked-off slot. A second run rewrites slot 0 to insert, so the strobe has to span the frame wrap. Each slot's strobe level, write mask and all three channel bytes are compared with a bench model that tracks the holding buffer, the repeat byte and the sequence state.

// File: rtl/pcmrt_pkg.sv
package pcmrt_pkg;
  localparam int NCH    = 3;
  localparam int BYTE_W = 8;
  localparam int ENT_W  = 5;

  typedef enum logic [1:0] {
    SRC_PCM  = 2'b00,
    SRC_INS  = 2'b01,
    SRC_PRBS = 2'b10,
    SRC_PREV = 2'b11
  } src_e;
endpackage

// File: rtl/pcmrt_timing.sv
module pcmrt_timing #(
  parameter int NSLOTS = 32,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  output logic [2:0]    bit_pos,
  output logic [SW-1:0] slot_pos,
  output logic [SW-1:0] slot_next,
  output logic          last_bit
);
  logic [2:0]    bit_q;
  logic [SW-1:0] slot_q;

  function automatic logic [SW-1:0] step(input logic [SW-1:0] s);
    return (s == SW'(NSLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  // fsync overrides the stored position in the cycle it is seen
  assign bit_pos   = fsync ? 3'd0 : bit_q;
  assign slot_pos  = fsync ? '0   : slot_q;
  assign last_bit  = (bit_pos == 3'd7);
  assign slot_next = step(slot_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      bit_q <= bit_pos + 3'd1;
      if (last_bit) slot_q <= slot_next;
      else          slot_q <= slot_pos;
    end
  end
endmodule

// File: rtl/pcmrt_table.sv
module pcmrt_table #(
  parameter int DEPTH = 32,
  parameter int AW = 5,
  parameter int W = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [1:0]    src_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign src_b   = mem[raddr_b][W-1 -: 2];
endmodule

// File: rtl/pcmrt_prbs.sv
module pcmrt_prbs (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic bit_out
);
  logic [14:0] lfsr;

  assign bit_out = lfsr[14] ^ lfsr[13];

  always_ff @(posedge clk) begin
    if (rst)      lfsr <= '1;
    else if (adv) lfsr <= {lfsr[13:0], bit_out};
  end
endmodule

// File: rtl/pcm_slot_router.sv
module pcm_slot_router
  import pcmrt_pkg::*;
#(
  parameter int NSLOTS = 32,
  localparam int SW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fsync,
  input  logic                  pcm_bit,
  input  logic                  ins_bit,
  input  logic                  cfg_we,
  input  logic [SW-1:0]         cfg_addr,
  input  logic [ENT_W-1:0]      cfg_data,
  output logic                  ins_strobe,
  output logic [NCH-1:0]        ch_we,
  output logic [NCH*BYTE_W-1:0] ch_data
);
  logic [2:0]        bit_pos;
  logic [SW-1:0]     slot_pos, slot_next;
  logic              last_bit;
  logic [ENT_W-1:0]  cur_ent;
  logic [1:0]        ahead_src;
  src_e              cur_src;
  logic [NCH-1:0]    cur_mask;
  logic              prbs_bit;

  logic [BYTE_W-2:0] pcm_sr, ins_sr, prbs_sr;
  logic [BYTE_W-1:0] ins_hold, prev_byte, sel_byte;

  pcmrt_timing #(.NSLOTS(NSLOTS), .SW(SW)) u_timing (
    .clk(clk), .rst(rst), .fsync(fsync),
    .bit_pos(bit_pos), .slot_pos(slot_pos),
    .slot_next(slot_next), .last_bit(last_bit)
  );

  pcmrt_table #(.DEPTH(NSLOTS), .AW(SW), .W(ENT_W)) u_table (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_data),
    .raddr_a(slot_pos), .rdata_a(cur_ent),
    .raddr_b(slot_next), .src_b(ahead_src)
  );

  assign cur_src  = src_e'(cur_ent[ENT_W-1 -: 2]);
  assign cur_mask = cur_ent[NCH-1:0];

  pcmrt_prbs u_prbs (
    .clk(clk), .rst(rst),
    .adv(cur_src == SRC_PRBS),
    .bit_out(prbs_bit)
  );

  // sampling for slot k+1's insert entry happens during slot k
  assign ins_strobe = (src_e'(ahead_src) == SRC_INS);

  always_comb begin
    unique case (cur_src)
      SRC_PCM:  sel_byte = {pcm_sr, pcm_bit};
      SRC_INS:  sel_byte = ins_hold;
      SRC_PRBS: sel_byte = {prbs_sr, prbs_bit};
      default:  sel_byte = prev_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_sr    <= '0;
      ins_sr    <= '0;
      prbs_sr   <= '0;
      ins_hold  <= '0;
      prev_byte <= '0;
      ch_we     <= '0;
    end else begin
      pcm_sr  <= {pcm_sr[BYTE_W-3:0], pcm_bit};
      ins_sr  <= {ins_sr[BYTE_W-3:0], ins_bit};
      prbs_sr <= {prbs_sr[BYTE_W-3:0], prbs_bit};
      ch_we   <= last_bit ? cur_mask : '0;
      if (last_bit) begin
        ins_hold  <= {ins_sr, ins_bit};
        prev_byte <= sel_byte;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        ch_data[i*BYTE_W +: BYTE_W] <= '0;
      else if (last_bit && cur_mask[i])
        ch_data[i*BYTE_W +: BYTE_W] <= sel_byte;
    end
  end
endmodule

// File: rtl/pcmrt_checker.sv
module pcmrt_checker
  import pcmrt_pkg::*;
#(
  parameter int SW = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  fsync,
  input logic                  cfg_we,
  input logic [2:0]            bit_pos,
  input logic [SW-1:0]         slot_pos,
  input logic                  last_bit,
  input logic                  ins_strobe,
  input logic [NCH-1:0]        ch_we,
  input logic [NCH*BYTE_W-1:0] ch_data
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_we == '0 && ch_data == '0));

  assert_we_slot_end_R2: assert property (@(posedge clk) disable iff (rst)
    (ch_we != '0) |-> $past(last_bit));

  assert_strobe_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_pos != 3'd0 && !$past(cfg_we)) |-> $stable(ins_strobe));

  assert_fsync_align_R9: assert property (@(posedge clk) disable iff (rst)
    fsync |=> (fsync || (bit_pos == 3'd1 && slot_pos == '0)));

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ch_we == '0) |-> $stable(ch_data));
endmodule

bind pcm_slot_router pcmrt_checker #(.SW(SW)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .cfg_we(cfg_we),
  .bit_pos(bit_pos), .slot_pos(slot_pos), .last_bit(last_bit),
  .ins_strobe(ins_strobe), .ch_we(ch_we), .ch_data(ch_data)
);

// File: tb/tb_pcm_slot_router.sv
module tb_pcm_slot_router;
  localparam int NS = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst = 1'b1, fsync = 1'b0, pcm_bit = 1'b0, ins_bit = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [4:0] cfg_data = '0;
  logic ins_strobe;
  logic [2:0] ch_we;
  logic [23:0] ch_data;

  always #4 clk = ~clk;  // 125 MHz

  pcm_slot_router #(.NSLOTS(NS)) dut (
    .clk(clk), .rst(rst), .fsync(fsync), .pcm_bit(pcm_bit), .ins_bit(ins_bit),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .ins_strobe(ins_strobe), .ch_we(ch_we), .ch_data(ch_data)
  );

  // {entry[20:16], pcm byte[15:8], insert byte[7:0]}; entry = {src, mask}
  localparam logic [20:0] VEC [NS] = '{
    {5'b00_001, 8'hA5, 8'h11},   // PCM -> ch0
    {5'b00_111, 8'h3C, 8'h22},   // PCM -> all channels
    {5'b11_010, 8'h00, 8'h33},   // repeat -> ch1
    {5'b00_000, 8'hC3, 8'h44},   // PCM discarded
    {5'b11_101, 8'hFF, 8'h55},   // repeat of discarded -> ch0, ch2
    {5'b10_100, 8'h0F, 8'h9E},   // pattern -> ch2
    {5'b01_011, 8'hF0, 8'h77},   // insert -> ch0, ch1
    {5'b10_001, 8'h81, 8'h88}    // pattern again -> ch0
  };

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [4:0]  ent [NS];
  logic [7:0]  m_prev, m_hold, m_last [3];
  logic [14:0] m_lfsr;
  logic [7:0]  frm = 8'd0;
  bit          pend = 1'b0;
  logic [2:0]  p_mask;
  string       p_req;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_hold = '0; m_lfsr = '1; pend = 1'b0;
    for (int i = 0; i < 3; i++) m_last[i] = '0;
  endtask

  task automatic check_pending();
    if (pend) begin
      chk(ch_we === p_mask, "R2 write mask", {29'd0, ch_we}, {29'd0, p_mask});
      for (int i = 0; i < 3; i++)
        chk(ch_data[i*8 +: 8] === m_last[i], p_mask[i] ? p_req : "R10 unwritten hold",
            {24'd0, ch_data[i*8 +: 8]}, {24'd0, m_last[i]});
      pend = 1'b0;
    end
  endtask

  task automatic run_frame(input bit use_fs, input bit second_run);
    for (int s = 0; s < NS; s++) begin
      logic [4:0] e;
      logic [7:0] pb, ib, sel;
      e  = ent[s];
      pb = VEC[s][15:8] ^ frm;
      ib = VEC[s][7:0] + frm;
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        if (b == 0) check_pending();
        rst = 1'b0;
        fsync   = use_fs && s == 0 && b == 0;  // R9
        pcm_bit = pb[7-b];
        ins_bit = ib[7-b];
        if (b == 3) begin
          #1;
          chk(ins_strobe === (ent[(s+1) % NS][4:3] == 2'b01), "R6 insert strobe",
              {31'd0, ins_strobe}, {31'd0, ent[(s+1) % NS][4:3] == 2'b01});
        end
        if (b == 4) chk(ch_we === 3'b000, "R2 idle mid-slot", {29'd0, ch_we}, 32'd0);
      end
      unique case (e[4:3])
        2'b00: begin sel = pb; p_req = "R3 pcm byte"; end
        2'b01: begin sel = m_hold; p_req = (second_run && s == 0) ? "R7 R11 insert wrap" : "R7 insert byte"; end
        2'b10: begin
          sel = '0;
          for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = m_lfsr[14] ^ m_lfsr[13];
            sel = {sel[6:0], fb};
            m_lfsr = {m_lfsr[13:0], fb};
          end
          p_req = "R8 pattern byte";
        end
        default: begin sel = m_prev; p_req = "R5 repeat byte"; end
      endcase
      if (e[2:0] == 3'b000) p_req = "R4 discard";
      m_hold = ib;
      m_prev = sel;
      for (int i = 0; i < 3; i++) if (e[i]) m_last[i] = sel;
      p_mask = e[2:0];
      pend = 1'b1;
    end
    frm = frm + 8'd1;
  endtask

  task automatic wr_entry(input int a, input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = v; ent[a] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    for (int s = 0; s < NS; s++) wr_entry(s, VEC[s][20:16]);
    @(negedge clk);
    chk(ch_we === 3'b000, "R1 reset we", {29'd0, ch_we}, 32'd0);
    chk(ch_data === 24'd0, "R1 reset data", {8'd0, ch_data}, 32'd0);

    // vector frames: fsync, free wrap, fsync again
    run_frame(1'b1, 1'b0);
    run_frame(1'b0, 1'b0);
    run_frame(1'b1, 1'b0);
    @(negedge clk);
    check_pending();

    // reset with live data on the outputs
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(ch_we === 3'b000, "R1 reset we after traffic", {29'd0, ch_we}, 32'd0);
    chk(ch_data === 24'd0, "R1 reset data after traffic", {8'd0, ch_data}, 32'd0);
    model_reset();

    // slot 0 becomes an insert slot: strobe must span the frame wrap
    wr_entry(0, 5'b01_100);
    run_frame(1'b1, 1'b1);
    run_frame(1'b0, 1'b1);
    @(negedge clk);
    check_pending();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule